// File: doc/BRIEF.md
# Dual Independent 32-bit Interval Timer

This block holds two 32-bit up-counters, a low half and a high half, that run side by side without being chained. Each half has a count register that software can load at any time and a period register that sets where the half wraps or stops. One shared control word holds a 2-bit run-mode field for each half. A separate global word holds a 2-bit counter-mode selector and a reset-release bit per half. A half counts only when it is released, the selector picks independent 32-bit operation, and its own field asks for one-shot or periodic running.

When a running half reaches its period, it gives a single-cycle interrupt pulse. A periodic half then restarts from zero. A one-shot half stops where it is and its mode field drops back to disabled. A typical use puts the high half in periodic mode with an all-ones period as a free-running timebase, and uses the low half as a one-shot event timer. The low half also has a compare register that raises a separate one-time match pulse. Writing that register arms the match again.

Software reaches the block through a plain 32-bit register bus. A write takes effect on the clock edge. A read returns data combinationally for the address presented.

Top module: `dual_timer`

## Requirements
- R1: The register map is: low count 0x10, high count 0x14, low period 0x18, high period 0x1C, control 0x20, global 0x24 and low compare 0x30. Period and compare registers read back the last value written. Control reads back only bits 7:6 and 23:22, and global reads back only bits 3:0. Every other bit and every unmapped address reads zero.
- R2: The run-mode field of the low half sits at control bits 7:6 and that of the high half at bits 23:22. Code 0 means disabled, 1 one-shot, 2 periodic. Code 3 behaves as disabled, so the count holds.
- R3: Global bit 0 releases the low half and bit 1 releases the high half. A half counts only when its bit is 1 and global bits 3:2 equal 01. Otherwise it holds its count and gives no pulse.
- R4: A running half whose count differs from its period adds one per clock. When the count equals the period, the half's interrupt output is high for exactly the following cycle.
- R5: In periodic mode, the count equal to the period is followed by zero, so pulses come every period+1 cycles.
- R6: In one-shot mode, reaching the period gives one pulse, keeps the count at the period and sets that half's field to 0. A control write in the same cycle overrides this clear.
- R7: Count registers read the live value. A bus write to a count register wins over the increment, the wrap and the pulse in that cycle.
- R8: With the period set to all ones in periodic mode, a half runs freely and wraps from 0xFFFFFFFF to 0 with one pulse.
- R9: The compare register resets to all ones and armed. The match output is high for the one cycle after the low count equals the compare value while armed, and this disarms it. A compare write re-arms it, and no match is produced in the cycle of the write.
- R10: After reset, both counts, both periods, control and global are zero and all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| irqLo | output | 1 | Low half terminal-count pulse |
| irqHi | output | 1 | High half terminal-count pulse |
| matchLo | output | 1 | Low half compare match pulse |

## Verification
The checker watches several rules on every cycle: an interrupt only follows a cycle in which count equalled period, a held or mode-3 half keeps its count, a bus count write lands exactly, a periodic pulse leaves the count at zero, and a one-shot pulse leaves the field disabled. Other properties need a scenario to show them. These are pulse spacing over whole periods, the one-shot firing only once, a wrap through all ones, the compare firing once and then firing again after a re-arm, and readback of every register. The bench shows these by comparing against its reference model each cycle and by directed reads.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
  localparam int TMR_W   = 32;
  localparam int HALVES  = 2;

  localparam int OFS_CNT_LO = 'h10;
  localparam int OFS_CNT_HI = 'h14;
  localparam int OFS_PRD_LO = 'h18;
  localparam int OFS_PRD_HI = 'h1C;
  localparam int OFS_CTRL   = 'h20;
  localparam int OFS_GCTL   = 'h24;
  localparam int OFS_CMP    = 'h30;

  localparam int MODE_LSB_LO = 6;
  localparam int MODE_LSB_HI = 22;
  localparam int GCTL_W      = 4;
  localparam logic [1:0] GMODE_INDEP = 2'b01;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_ONCE = 2'd1,
    MODE_LOOP = 2'd2,
    MODE_RSV  = 2'd3
  } runMode_e;

  typedef struct packed {
    logic [HALVES-1:0] cntWr;
    logic [HALVES-1:0] prdWr;
    logic              cmpWr;
    logic [HALVES-1:0] run;
    logic [HALVES-1:0] reloadOnHit;
  } dpStrobe_t;

  function automatic int cntOfs(input int h);
    return (h == 0) ? OFS_CNT_LO : OFS_CNT_HI;
  endfunction

  function automatic int prdOfs(input int h);
    return (h == 0) ? OFS_PRD_LO : OFS_PRD_HI;
  endfunction

  function automatic int modeLsb(input int h);
    return (h == 0) ? MODE_LSB_LO : MODE_LSB_HI;
  endfunction
endpackage

// File: rtl/dual_timer_ctrl.sv
module dual_timer_ctrl
  import dual_timer_pkg::*;
#(
  parameter int DATA_W = TMR_W,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [HALVES-1:0] termHit,
  input  logic [DATA_W-1:0] cntVal [HALVES],
  input  logic [DATA_W-1:0] prdVal [HALVES],
  input  logic [DATA_W-1:0] cmpVal,
  output dpStrobe_t         strb,
  output runMode_e          modeQ [HALVES],
  output logic [GCTL_W-1:0] gctlQ,
  output logic [DATA_W-1:0] busRdata
);
  logic ctrlWr;
  logic gctlWr;
  logic unusedWdata;

  assign ctrlWr = busWrEn && (busAddr == ADDR_W'(OFS_CTRL));
  assign gctlWr = busWrEn && (busAddr == ADDR_W'(OFS_GCTL));
  assign unusedWdata = ^busWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gctlQ <= '0;
      for (int h = 0; h < HALVES; h++) modeQ[h] <= MODE_OFF;
    end else begin
      if (gctlWr) gctlQ <= busWdata[GCTL_W-1:0];
      for (int h = 0; h < HALVES; h++) begin
        if (ctrlWr)
          modeQ[h] <= runMode_e'(busWdata[modeLsb(h) +: 2]);
        else if (termHit[h] && modeQ[h] == MODE_ONCE)
          modeQ[h] <= MODE_OFF;
      end
    end
  end

  always_comb begin
    strb.cmpWr = busWrEn && (busAddr == ADDR_W'(OFS_CMP));
    for (int h = 0; h < HALVES; h++) begin
      strb.cntWr[h]       = busWrEn && (busAddr == ADDR_W'(cntOfs(h)));
      strb.prdWr[h]       = busWrEn && (busAddr == ADDR_W'(prdOfs(h)));
      strb.run[h]         = gctlQ[h] && (gctlQ[3:2] == GMODE_INDEP) &&
                            (modeQ[h] == MODE_ONCE || modeQ[h] == MODE_LOOP);
      strb.reloadOnHit[h] = (modeQ[h] == MODE_LOOP);
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(OFS_CNT_LO): busRdata = cntVal[0];
      ADDR_W'(OFS_CNT_HI): busRdata = cntVal[1];
      ADDR_W'(OFS_PRD_LO): busRdata = prdVal[0];
      ADDR_W'(OFS_PRD_HI): busRdata = prdVal[1];
      ADDR_W'(OFS_CMP):    busRdata = cmpVal;
      ADDR_W'(OFS_GCTL):   busRdata[GCTL_W-1:0] = gctlQ;
      ADDR_W'(OFS_CTRL): begin
        busRdata[MODE_LSB_LO +: 2] = modeQ[0];
        busRdata[MODE_LSB_HI +: 2] = modeQ[1];
      end
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_timer_dp.sv
module dual_timer_dp
  import dual_timer_pkg::*;
#(
  parameter int DATA_W = TMR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cntQ [HALVES],
  output logic [DATA_W-1:0] prdQ [HALVES],
  output logic [DATA_W-1:0] cmpQ,
  output logic [HALVES-1:0] termHit,
  output logic [HALVES-1:0] irqQ,
  output logic              matchQ
);
  logic armQ;
  logic cmpEq;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign termHit[h] = strb.run[h] && !strb.cntWr[h] && (cntQ[h] == prdQ[h]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ[h] <= '0;
        prdQ[h] <= '0;
        irqQ[h] <= 1'b0;
      end else begin
        irqQ[h] <= termHit[h];
        if (strb.prdWr[h]) prdQ[h] <= wdata;
        if (strb.cntWr[h])
          cntQ[h] <= wdata;
        else if (termHit[h]) begin
          if (strb.reloadOnHit[h]) cntQ[h] <= '0;
        end else if (strb.run[h])
          cntQ[h] <= cntQ[h] + 1'b1;
      end
    end
  end

  assign cmpEq = armQ && (cntQ[0] == cmpQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpQ   <= '1;
      armQ   <= 1'b1;
      matchQ <= 1'b0;
    end else begin
      matchQ <= cmpEq && !strb.cmpWr;
      if (strb.cmpWr) begin
        cmpQ <= wdata;
        armQ <= 1'b1;
      end else if (cmpEq) begin
        armQ <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dual_timer_pkg::*;
#(
  parameter int DATA_W = TMR_W,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqLo,
  output logic              irqHi,
  output logic              matchLo
);
  dpStrobe_t         strb;
  runMode_e          modeQ [HALVES];
  logic [GCTL_W-1:0] gctlQ;
  logic [DATA_W-1:0] cntVal [HALVES];
  logic [DATA_W-1:0] prdVal [HALVES];
  logic [DATA_W-1:0] cmpVal;
  logic [HALVES-1:0] termHit;
  logic [HALVES-1:0] irqQ;

  dual_timer_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .termHit(termHit), .cntVal(cntVal),
    .prdVal(prdVal), .cmpVal(cmpVal), .strb(strb), .modeQ(modeQ),
    .gctlQ(gctlQ), .busRdata(busRdata)
  );

  dual_timer_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata),
    .cntQ(cntVal), .prdQ(prdVal), .cmpQ(cmpVal), .termHit(termHit),
    .irqQ(irqQ), .matchQ(matchLo)
  );

  assign irqLo = irqQ[0];
  assign irqHi = irqQ[1];
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk
  import dual_timer_pkg::*;
#(
  parameter int DATA_W = TMR_W,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              irqLo,
  input logic              irqHi,
  input logic              matchLo,
  input logic [DATA_W-1:0] cntLo,
  input logic [DATA_W-1:0] cntHi,
  input logic [DATA_W-1:0] prdLo,
  input logic [DATA_W-1:0] cmpLo,
  input logic [1:0]        modeLo,
  input logic [1:0]        modeHi,
  input logic [GCTL_W-1:0] gctl
);
  logic wrCntLo, wrCntHi, wrCtrl;
  assign wrCntLo = busWrEn && busAddr == ADDR_W'(OFS_CNT_LO);
  assign wrCntHi = busWrEn && busAddr == ADDR_W'(OFS_CNT_HI);
  assign wrCtrl  = busWrEn && busAddr == ADDR_W'(OFS_CTRL);

  AST_IRQ_AT_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    irqLo |-> $past(cntLo == prdLo)); // R4
  AST_IRQ_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    irqHi |-> $past(gctl[1]) && $past(gctl[3:2] == 2'b01)); // R3
  AST_HELD_NO_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (!gctl[0] && !wrCntLo) |=> $stable(cntLo)); // R3
  AST_MODE3_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (modeLo == 2'd3 && !wrCntLo) |=> $stable(cntLo)); // R2
  AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    wrCntLo |=> cntLo == $past(busWdata)); // R7
  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (irqHi && $past(modeHi == 2'd2) && !$past(wrCntHi)) |-> cntHi == '0); // R5
  AST_ONESHOT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (irqLo && $past(modeLo == 2'd1) && !$past(wrCtrl)) |-> modeLo == 2'd0); // R6
  AST_MATCH_EQUAL: assert property (@(posedge clk) disable iff (!rstN)
    matchLo |-> $past(cntLo == cmpLo)); // R9
endmodule

bind dual_timer dual_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWdata(busWdata), .irqLo(irqLo), .irqHi(irqHi), .matchLo(matchLo),
  .cntLo(cntVal[0]), .cntHi(cntVal[1]), .prdLo(prdVal[0]), .cmpLo(cmpVal),
  .modeLo(modeQ[0]), .modeHi(modeQ[1]), .gctl(gctlQ)
);

// File: tb/dual_timer_tb_top.sv
module dual_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic        irqLo, irqHi, matchLo;

  int total = 0, bad = 0, cyc = 0;
  int nIrqLo = 0, nIrqHi = 0, nMatch = 0;
  bit live = 0, done = 0;

  always #10 clk = ~clk;

  dual_timer dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqLo(irqLo),
    .irqHi(irqHi), .matchLo(matchLo)
  );

  // behavioural reference model
  bit [31:0] mCnt [2] = '{0, 0};
  bit [31:0] mPrd [2] = '{0, 0};
  bit [1:0]  mMode [2] = '{0, 0};
  bit [3:0]  mG = 0;
  bit [31:0] mCmp = 32'hFFFF_FFFF;
  bit        mArm = 1, mMatch = 0;
  bit        mIrq [2] = '{0, 0};

  always @(posedge clk) begin
    bit        run, hit, wrC, matchNow;
    bit [31:0] oldLo;
    cyc++;
    if (!rstN) begin
      mCnt = '{0, 0}; mPrd = '{0, 0}; mMode = '{0, 0}; mG = 0;
      mCmp = 32'hFFFF_FFFF; mArm = 1; mMatch = 0; mIrq = '{0, 0};
    end else begin
      oldLo = mCnt[0];
      matchNow = mArm && (oldLo == mCmp);
      mMatch = matchNow && !(busWrEn && busAddr == 8'h30);
      if (busWrEn && busAddr == 8'h30) begin mCmp = busWdata; mArm = 1; end
      else if (matchNow) mArm = 0;
      for (int h = 0; h < 2; h++) begin
        run = mG[h] && mG[3:2] == 2'b01 && (mMode[h] == 1 || mMode[h] == 2);
        wrC = busWrEn && busAddr == (h == 0 ? 8'h10 : 8'h14);
        hit = run && !wrC && mCnt[h] == mPrd[h];
        mIrq[h] = hit;
        if (wrC) mCnt[h] = busWdata;
        else if (hit) begin if (mMode[h] == 2) mCnt[h] = 0; end
        else if (run) mCnt[h] = mCnt[h] + 1;
        if (busWrEn && busAddr == (h == 0 ? 8'h18 : 8'h1C)) mPrd[h] = busWdata;
        if (busWrEn && busAddr == 8'h20)
          mMode[h] = (h == 0) ? busWdata[7:6] : busWdata[23:22];
        else if (hit && mMode[h] == 1) mMode[h] = 0;
      end
      if (busWrEn && busAddr == 8'h24) mG = busWdata[3:0];
    end
  end

  function automatic bit [31:0] mRead(input bit [7:0] a);
    case (a)
      8'h10: return mCnt[0];
      8'h14: return mCnt[1];
      8'h18: return mPrd[0];
      8'h1C: return mPrd[1];
      8'h20: return {8'b0, mMode[1], 14'b0, mMode[0], 6'b0};
      8'h24: return {28'b0, mG};
      8'h30: return mCmp;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input bit [31:0] act, input bit [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (live && rstN) begin
      chk("R4 irqLo vs model", irqLo, mIrq[0]);
      chk("R4 irqHi vs model", irqHi, mIrq[1]);
      chk("R9 matchLo vs model", matchLo, mMatch);
      if (busAddr == 8'h10 || busAddr == 8'h14) chk("R7 live count read", busRdata, mRead(busAddr));
      else chk("R1 register read", busRdata, mRead(busAddr));
      if (irqLo) nIrqLo++;
      if (irqHi) nIrqHi++;
      if (matchLo) nMatch++;
    end
  end

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    @(posedge clk); #1;
    busWrEn = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busWrEn = 0;
  endtask

  task automatic rdExp(input bit [7:0] a, input bit [31:0] exp, input string tag);
    @(posedge clk); #1; busAddr = a;
    @(negedge clk); chk(tag, busRdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic gap(input bit hi, output int g);
    int t0;
    @(negedge clk);
    while (!(hi ? irqHi : irqLo)) @(negedge clk);
    t0 = cyc;
    @(negedge clk);
    while (!(hi ? irqHi : irqLo)) @(negedge clk);
    g = cyc - t0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int g;
    bit [31:0] v;
    idle(3); #1; rstN = 1; live = 1;
    // R10 reset state
    @(negedge clk);
    chk("R10 irqLo reset", irqLo, 0);
    chk("R10 irqHi reset", irqHi, 0);
    chk("R10 matchLo reset", matchLo, 0);
    rdExp(8'h10, 0, "R10 low count reset");
    rdExp(8'h1C, 0, "R10 high period reset");
    rdExp(8'h20, 0, "R10 control reset");
    rdExp(8'h24, 0, "R10 global reset");
    rdExp(8'h30, 32'hFFFF_FFFF, "R9 compare reset all ones");

    // R3 both held, mode 01
    wr(8'h20, 32'h0080_0080);
    wr(8'h24, 32'h4);
    nIrqLo = 0; idle(10);
    rdExp(8'h10, 0, "R3 held low half does not count");
    chk("R3 held half gives no pulse", nIrqLo, 0);
    // R3 released but counter mode 00
    wr(8'h24, 32'h3); idle(10);
    rdExp(8'h14, 0, "R3 counter mode 00 does not count");

    // R4/R5 periodic spacing
    wr(8'h18, 3); wr(8'h1C, 5); wr(8'h24, 32'h7);
    gap(0, g); chk("R5 low periodic spacing", g, 4);
    gap(1, g); chk("R5 high periodic spacing", g, 6);

    // R7 count write, R2 disabled holds
    wr(8'h20, 32'h0080_0000);
    wr(8'h10, 32'h1234); idle(4);
    rdExp(8'h10, 32'h1234, "R7 written count held while disabled");

    // R6 one-shot
    wr(8'h10, 0); wr(8'h18, 3);
    nIrqLo = 0;
    wr(8'h20, 32'h0080_0040); idle(20);
    chk("R6 one-shot pulses once", nIrqLo, 1);
    rdExp(8'h10, 3, "R6 one-shot holds count at period");
    rdExp(8'h20, 32'h0080_0000, "R6 one-shot field cleared");

    // R2 code 3
    wr(8'h20, 32'h0080_00C0); wr(8'h10, 0); idle(8);
    rdExp(8'h10, 0, "R2 mode code 3 does not count");
    rdExp(8'h20, 32'h0080_00C0, "R1 control readback");

    // R8 wrap with all-ones period, R9 default compare
    wr(8'h20, 32'h0080_0000);
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h10, 32'hFFFF_FFFC);
    nIrqLo = 0; nMatch = 0;
    wr(8'h20, 32'h0080_0080); idle(12);
    @(posedge clk); #1; busAddr = 8'h10; @(negedge clk); v = busRdata;
    chk("R8 count wrapped to small value", v < 16, 1);
    chk("R8 one pulse on wrap", nIrqLo, 1);
    chk("R9 reset compare matches once at all ones", nMatch, 1);

    // R9 compare and re-arm
    wr(8'h20, 32'h0080_0000); wr(8'h10, 0); wr(8'h18, 40);
    wr(8'h30, 20); nMatch = 0;
    wr(8'h20, 32'h0080_0080); idle(100);
    chk("R9 match fires once until re-armed", nMatch, 1);
    wr(8'h30, 20); idle(50);
    chk("R9 compare write re-arms", nMatch, 2);
    rdExp(8'h30, 20, "R1 compare readback");
    rdExp(8'h18, 40, "R1 low period readback");
    rdExp(8'h24, 7, "R1 global readback");
    rdExp(8'h00, 0, "R1 unmapped read zero");
    rdExp(8'h3C, 0, "R1 unmapped read zero high");

    // R3 high held mid-run
    wr(8'h24, 32'h5);
    @(posedge clk); #1; busAddr = 8'h14; @(negedge clk); v = busRdata;
    nIrqHi = 0; idle(20);
    rdExp(8'h14, v, "R3 held high half keeps count");
    chk("R3 held high half no pulse", nIrqHi, 0);

    idle(5);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule